// File: doc/BRIEF.md
# USB Host Frame Scheduler

This block sets the frame rhythm for a USB host controller. It runs from a 48 MHz clock and counts out one frame every 1 ms. At each frame start it sends a single-cycle marker request to the packet layer. In full-speed operation the marker asks for a start-of-frame token. In low-speed operation it asks for a bare end-of-packet keep-alive. The block also keeps an 11-bit frame number that advances with every marker.

Firmware may load a host transfer request at any moment. The scheduler holds the request and launches it only inside the safe part of a frame. The launch window opens after the marker cycle and closes a guard interval before the frame ends. The packet layer reports the peripheral's handshake when the transfer finishes. The scheduler then raises a one-cycle interrupt with a result code. It also keeps the DATA0/DATA1 toggle that the next packet of a multipacket transfer must carry.

Top module: `usb_frame_sched`

## Requirements
- R1: While `frame_en` is high, a marker pulse appears at every FRAME_CLKS-th rising edge counted from the first edge at which `frame_en` is sampled high, and at no other edge.
- R2: A marker drives `mark_sof` when `low_speed` was 0 at the edge that produced it, and `mark_eop` when it was 1. Each marker is one cycle wide, and the two outputs are never high together.
- R3: `frame_num` advances by one at each marker. It wraps from 2047 to 0 and otherwise holds its value.
- R4: While `frame_en` is low, the frame counter and `frame_num` read 0 and no marker or launch occurs. After reset every output reads 0.
- R5: A loaded request raises `launch` (together with `data_tog`) in the first cycle in which `frame_en` is high and the frame counter lies in 1 .. FRAME_CLKS-GUARD_CLKS-1. A request that arrives inside the guard window or while disabled is held until that point.
- R6: Each request launches exactly once. `busy` is high from the edge after the load until the completion edge, and `xfer_load` is ignored while `busy` is high.
- R7: An OUT transfer (`xfer_in`=0) completing with ACK (`done_hs`=0) gives result 0 and inverts `data_tog`.
- R8: An IN transfer completing with ACK gives result 0 and inverts `data_tog` when `done_rx_tog` equals `data_tog`. When they differ it gives result 3 (toggle mismatch) and keeps `data_tog`.
- R9: Completion with NAK (`done_hs`=1), STALL (2) or timeout (3) gives result 1, 2 or 4 respectively and keeps `data_tog`.
- R10: `xfer_irq` pulses for one cycle, one edge after `done_valid` is sampled while a transfer is in flight. `done_valid` outside that state has no effect.
- R11: `tog_load` copies `tog_val` into `data_tog` at the next edge when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_en | input | 1 | Frame generation enable; low clears counter and number |
| low_speed | input | 1 | 1 selects end-of-packet keep-alive markers |
| xfer_load | input | 1 | Load a transfer request |
| xfer_in | input | 1 | Direction of the loaded request, 1 = IN |
| done_valid | input | 1 | Packet layer reports transfer end |
| done_hs | input | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL, 3 timeout |
| done_rx_tog | input | 1 | Toggle of received DATA packet (IN) |
| tog_load | input | 1 | Force the data toggle |
| tog_val | input | 1 | Value for the forced toggle |
| mark_sof | output | 1 | Start-of-frame token request |
| mark_eop | output | 1 | Low-speed keep-alive request |
| frame_num | output | FN_W | Current frame number |
| launch | output | 1 | Transfer launch strobe |
| data_tog | output | 1 | Expected/outgoing DATA0/DATA1 toggle |
| busy | output | 1 | Request pending or in flight |
| xfer_irq | output | 1 | Completion interrupt pulse |
| xfer_result | output | 3 | Result code of last completion |

## Verification
Markers and the new frame number appear at the same edge that ends the frame's last counter cycle. The bench therefore keeps its own count of enabled edges and expects a marker whenever that count is a nonzero multiple of the frame length. `launch` is combinational from the registered pending state and counter. The bench computes the first enabled edge at or after the load edge whose counter value falls inside the window, and it requires `launch` at exactly that sample and nowhere before it. The interrupt, result code and new toggle register one edge after `done_valid` is sampled. The bench drives `done_valid` one cycle after the launch sample and checks all three at the following sample. All inputs change 1 ns after a rising edge, and all outputs are sampled at that same point.

// File: rtl/usb_fsched_pkg.sv
package usb_fsched_pkg;

  typedef enum logic [1:0] {
    HS_ACK     = 2'd0,
    HS_NAK     = 2'd1,
    HS_STALL   = 2'd2,
    HS_TIMEOUT = 2'd3
  } hs_e;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_NAK     = 3'd1,
    RES_STALL   = 3'd2,
    RES_TOGGLE  = 3'd3,
    RES_TIMEOUT = 3'd4
  } res_e;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_PEND   = 2'd1,
    XS_FLIGHT = 2'd2
  } xs_e;

endpackage

// File: rtl/ufs_frame_timer.sv
module ufs_frame_timer #(
  parameter int FRAME_CLKS = 48000,
  parameter int FN_W       = 11,
  parameter int CNT_W      = $clog2(FRAME_CLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ls_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [FN_W-1:0]  fn_o,
  output logic             sof_o,
  output logic             eop_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FN_W-1:0]  fn_q, fn_d;
  logic             mark_q, mark_d;
  logic             kind_q;
  logic             wrap;

  assign wrap = en_i && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    fn_d   = fn_q;
    mark_d = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
      fn_d  = '0;
    end else if (wrap) begin
      cnt_d  = '0;
      fn_d   = fn_q + FN_W'(1);
      mark_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fn_q   <= '0;
      mark_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fn_q   <= fn_d;
      mark_q <= mark_d;
    end
  end

  // marker kind is captured only at the frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= 1'b0;
    end else if (wrap) begin
      kind_q <= ls_i;
    end
  end

  assign cnt_o = cnt_q;
  assign fn_o  = fn_q;
  assign sof_o = mark_q & ~kind_q;
  assign eop_o = mark_q & kind_q;

  // R2
  marker_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sof_o, eop_o}));

  // R3
  fn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o || eop_o) |-> (fn_o == FN_W'($past(fn_o) + FN_W'(1))));

  // R4
  disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fn_o == '0 && cnt_o == '0 && !sof_o && !eop_o));

endmodule

// File: rtl/ufs_launch_gate.sv
module ufs_launch_gate
  import usb_fsched_pkg::*;
#(
  parameter int FRAME_CLKS = 48000,
  parameter int GUARD_CLKS = 600,
  parameter int CNT_W      = $clog2(FRAME_CLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             load_i,
  input  logic             dir_i,
  input  logic             done_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             dir_o,
  output logic             accept_o
);
  localparam logic [CNT_W-1:0] OPEN_END = CNT_W'(FRAME_CLKS - GUARD_CLKS);

  xs_e  st_q, st_d;
  logic dir_q;
  logic win;
  logic take;

  assign win  = en_i && (cnt_i != '0) && (cnt_i < OPEN_END);
  assign take = (st_q == XS_IDLE) && load_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      XS_IDLE:   if (load_i) st_d = XS_PEND;
      XS_PEND:   if (win)    st_d = XS_FLIGHT;
      XS_FLIGHT: if (done_i) st_d = XS_IDLE;
      default:               st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= XS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
    end else if (take) begin
      dir_q <= dir_i;
    end
  end

  assign launch_o = (st_q == XS_PEND) && win;
  assign accept_o = (st_q == XS_FLIGHT) && done_i;
  assign busy_o   = (st_q != XS_IDLE);
  assign dir_o    = dir_q;

  // R6
  single_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> (!launch_o && busy_o));

  // R4
  no_launch_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !launch_o);

endmodule

// File: rtl/ufs_xfer_result.sv
module ufs_xfer_result
  import usb_fsched_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       dir_in_i,
  input  logic [1:0] hs_i,
  input  logic       rx_tog_i,
  input  logic       tog_load_i,
  input  logic       tog_val_i,
  input  logic       busy_i,
  output logic       tog_o,
  output logic       irq_o,
  output logic [2:0] res_o
);
  logic tog_q, tog_d;
  logic irq_q;
  res_e res_q, res_d;
  logic flip;

  always_comb begin
    res_d = RES_OK;
    flip  = 1'b0;
    unique case (hs_e'(hs_i))
      HS_ACK: begin
        if (dir_in_i && (rx_tog_i != tog_q)) begin
          res_d = RES_TOGGLE;
        end else begin
          flip = 1'b1;
        end
      end
      HS_NAK:     res_d = RES_NAK;
      HS_STALL:   res_d = RES_STALL;
      HS_TIMEOUT: res_d = RES_TIMEOUT;
      default:    res_d = RES_TIMEOUT;
    endcase
  end

  always_comb begin
    tog_d = tog_q;
    if (accept_i) begin
      if (flip) tog_d = ~tog_q;
    end else if (tog_load_i && !busy_i) begin
      tog_d = tog_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      irq_q <= accept_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= RES_OK;
    end else if (accept_i) begin
      res_q <= res_d;
    end
  end

  assign tog_o = tog_q;
  assign irq_o = irq_q;
  assign res_o = res_q;

  // R7
  ok_flips_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && res_o == RES_OK) |-> (tog_o != $past(tog_o)));

  // R9
  fail_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && res_o != RES_OK) |-> (tog_o == $past(tog_o)));

endmodule

// File: rtl/usb_frame_sched.sv
module usb_frame_sched
  import usb_fsched_pkg::*;
#(
  parameter int FRAME_CLKS = 48000,
  parameter int GUARD_CLKS = 600,
  parameter int FN_W       = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_en,
  input  logic            low_speed,
  input  logic            xfer_load,
  input  logic            xfer_in,
  input  logic            done_valid,
  input  logic [1:0]      done_hs,
  input  logic            done_rx_tog,
  input  logic            tog_load,
  input  logic            tog_val,
  output logic            mark_sof,
  output logic            mark_eop,
  output logic [FN_W-1:0] frame_num,
  output logic            launch,
  output logic            data_tog,
  output logic            busy,
  output logic            xfer_irq,
  output logic [2:0]      xfer_result
);
  localparam int CNT_W = $clog2(FRAME_CLKS);

  logic [1:0]       rs_q;
  logic             rst_ni;
  logic [CNT_W-1:0] cnt;
  logic             dir_in;
  logic             accept;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_ni = rs_q[1];

  ufs_frame_timer #(
    .FRAME_CLKS(FRAME_CLKS),
    .FN_W      (FN_W),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .en_i  (frame_en),
    .ls_i  (low_speed),
    .cnt_o (cnt),
    .fn_o  (frame_num),
    .sof_o (mark_sof),
    .eop_o (mark_eop)
  );

  ufs_launch_gate #(
    .FRAME_CLKS(FRAME_CLKS),
    .GUARD_CLKS(GUARD_CLKS),
    .CNT_W     (CNT_W)
  ) u_gate (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .en_i    (frame_en),
    .cnt_i   (cnt),
    .load_i  (xfer_load),
    .dir_i   (xfer_in),
    .done_i  (done_valid),
    .launch_o(launch),
    .busy_o  (busy),
    .dir_o   (dir_in),
    .accept_o(accept)
  );

  ufs_xfer_result u_result (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .dir_in_i  (dir_in),
    .hs_i      (done_hs),
    .rx_tog_i  (done_rx_tog),
    .tog_load_i(tog_load),
    .tog_val_i (tog_val),
    .busy_i    (busy),
    .tog_o     (data_tog),
    .irq_o     (xfer_irq),
    .res_o     (xfer_result)
  );

  // R10
  irq_after_flight_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer_irq |-> ($past(busy) && !busy));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer_irq |=> !xfer_irq);

endmodule

// File: tb/sim_usb_frame_sched.sv
module sim_usb_frame_sched;
  localparam int F    = 24;
  localparam int G    = 6;
  localparam int FNW  = 11;
  localparam int OPEN = F - G;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_en, low_speed, xfer_load, xfer_in, done_valid, done_rx_tog;
  logic tog_load, tog_val;
  logic [1:0] done_hs;
  logic mark_sof, mark_eop, launch, data_tog, busy, xfer_irq;
  logic [FNW-1:0] frame_num;
  logic [2:0] xfer_result;

  int checks = 0;
  int fails  = 0;
  int k_en   = 0;
  int cyc    = 0;
  bit exp_tog = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  usb_frame_sched #(.FRAME_CLKS(F), .GUARD_CLKS(G), .FN_W(FNW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .low_speed(low_speed),
    .xfer_load(xfer_load), .xfer_in(xfer_in), .done_valid(done_valid),
    .done_hs(done_hs), .done_rx_tog(done_rx_tog), .tog_load(tog_load),
    .tog_val(tog_val), .mark_sof(mark_sof), .mark_eop(mark_eop),
    .frame_num(frame_num), .launch(launch), .data_tog(data_tog), .busy(busy),
    .xfer_irq(xfer_irq), .xfer_result(xfer_result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // one clock: model the enabled-edge count, then check markers and number
  task automatic tick();
    bit mexp, sexp, eexp;
    int fexp;
    @(posedge clk);
    if (frame_en) k_en++; else k_en = 0;
    mexp = frame_en && (k_en > 0) && (k_en % F == 0);
    sexp = mexp && !low_speed;
    eexp = mexp && low_speed;
    fexp = (k_en / F) % 2048;
    #1;
    chk((mark_sof | mark_eop) == mexp, "R1 marker", int'(mark_sof | mark_eop), int'(mexp));
    chk(mark_sof == sexp && mark_eop == eexp, "R2 kind",
        int'({mark_sof, mark_eop}), int'({sexp, eexp}));
    chk(int'(frame_num) == fexp, "R3 number", int'(frame_num), fexp);
  endtask

  function automatic int first_launch(input int k0);
    int k = k0;
    while (!((k % F) >= 1 && (k % F) <= OPEN - 1)) k++;
    return k;
  endfunction

  // complete an in-flight transfer and check the result
  task automatic finish_xfer(input bit dir, input int hs, input bit rx);
    int  rexp;
    bit  flip;
    done_valid  = 1'b1;
    done_hs     = 2'(hs);
    done_rx_tog = rx;
    tick();
    done_valid = 1'b0;
    flip = 1'b0;
    case (hs)
      0: begin
        if (dir && rx != exp_tog) rexp = 3;
        else begin rexp = 0; flip = 1'b1; end
      end
      1: rexp = 1;
      2: rexp = 2;
      default: rexp = 4;
    endcase
    if (flip) exp_tog = ~exp_tog;
    chk(xfer_irq == 1'b1, "R10 irq", int'(xfer_irq), 1);
    if (hs == 0 && !dir)     chk(int'(xfer_result) == rexp, "R7 result", int'(xfer_result), rexp);
    else if (hs == 0)        chk(int'(xfer_result) == rexp, "R8 result", int'(xfer_result), rexp);
    else                     chk(int'(xfer_result) == rexp, "R9 result", int'(xfer_result), rexp);
    chk(data_tog == exp_tog, "R8 toggle", int'(data_tog), int'(exp_tog));
    chk(busy == 1'b0, "R6 busy clear", int'(busy), 0);
    tick();
    chk(xfer_irq == 1'b0, "R10 pulse", int'(xfer_irq), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !finished) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    frame_en = 0; low_speed = 0; xfer_load = 0; xfer_in = 0;
    done_valid = 0; done_hs = 0; done_rx_tog = 0; tog_load = 0; tog_val = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    // R4 reset state
    chk(launch == 0 && busy == 0 && xfer_irq == 0, "R4 reset ctl",
        int'({launch, busy, xfer_irq}), 0);
    chk(xfer_result == 0 && data_tog == 0, "R4 reset data",
        int'({xfer_result, data_tog}), 0);

    // R11 forced toggle while idle
    tog_load = 1; tog_val = 1; tick(); tog_load = 0; exp_tog = 1;
    chk(data_tog == 1'b1, "R11 set", int'(data_tog), 1);
    tog_load = 1; tog_val = 0; tick(); tog_load = 0; exp_tog = 0;
    chk(data_tog == 1'b0, "R11 clear", int'(data_tog), 0);

    // R10 done while idle has no effect
    done_valid = 1; done_hs = 0; tick(); done_valid = 0;
    chk(xfer_irq == 1'b0 && data_tog == exp_tog, "R10 idle done",
        int'({xfer_irq, data_tog}), int'({1'b0, exp_tog}));

    // R1 first marker after F enabled edges
    frame_en = 1;
    repeat (F) tick();
    chk(mark_sof == 1'b1, "R1 first", int'(mark_sof), 1);

    // R5..R9 sweep the load phase over every counter value of a frame
    for (int idx = 0; idx < F; idx++) begin
      int  kx;
      bit  dir;
      int  hs;
      bit  rx;
      dir = idx[0];
      hs  = (idx / 2) % 4;
      while (k_en % F != idx) tick();
      xfer_load = 1; xfer_in = dir;
      tick();
      kx = first_launch(k_en);
      chk(busy == 1'b1, "R6 busy set", int'(busy), 1);
      // second load while busy: must be ignored (R6)
      xfer_in = ~dir;
      while (k_en < kx) begin
        chk(launch == 1'b0, "R5 held", int'(launch), 0);
        tick();
        xfer_load = 0;
      end
      xfer_load = 0;
      chk(launch == 1'b1, "R5 launch", int'(launch), 1);
      chk(data_tog == exp_tog, "R5 toggle out", int'(data_tog), int'(exp_tog));
      tick();
      chk(launch == 1'b0, "R6 once", int'(launch), 0);
      rx = (idx % 3 == 0) ? ~exp_tog : exp_tog;
      finish_xfer(dir, hs, rx);
      // R6: the ignored second load must not produce another launch
      for (int j = 0; j < F; j++) begin
        chk(launch == 1'b0 && busy == 1'b0, "R6 ignored load",
            int'({launch, busy}), 0);
        tick();
      end
    end

    // R4 disable clears and holds a request; R5 launch at counter 1 on return
    frame_en = 0;
    tick();
    chk(frame_num == '0, "R4 cleared", int'(frame_num), 0);
    xfer_load = 1; xfer_in = 0;
    tick();
    xfer_load = 0;
    for (int j = 0; j < 30; j++) begin
      chk(launch == 1'b0 && busy == 1'b1, "R4 held while off",
          int'({launch, busy}), 1);
      tick();
    end
    frame_en = 1;
    tick();
    chk(launch == 1'b1, "R5 launch after enable", int'(launch), 1);
    tick();
    finish_xfer(1'b0, 0, 1'b0);

    // R2 low-speed markers for a span, R3 wrap of the frame number
    while (k_en < 100 * F + 5) tick();
    low_speed = 1;
    while (k_en < 140 * F + 5) tick();
    low_speed = 0;
    while (k_en < 2047 * F) tick();
    chk(int'(frame_num) == 2047, "R3 top", int'(frame_num), 2047);
    while (k_en < 2048 * F) tick();
    chk(frame_num == '0 && mark_sof == 1'b1, "R3 wrap",
        int'(frame_num), 0);
    repeat (F + 2) tick();
    summary();
  end
endmodule